// File: doc/BRIEF.md
# Bus Transmit Guard and Receive Path

This block sits between the transmit-data input of a single-wire bus transceiver and the enable of its bus driver while the transceiver is in normal mode. A low level on the transmit input asks for a dominant bus level. The block turns that request into a drive command, but it forces the bus recessive in three cases. The first is a transmit input held low for too long. The second is an active thermal-shutdown flag. The third is a battery undervoltage reported by a pair of monitor comparators.

Each fault recovers in its own way. A timeout ends once the transmit input is sampled high. A thermal lockout stays in force after the flag clears, until a high transmit level is sampled. An undervoltage block follows low and high battery thresholds with hysteresis. The undervoltage block never touches the mode or the receive path.

The receive path maps the bus level to the receive output. A dominant bus pulls the output low, and a recessive bus releases it high. Outside normal mode the receive output is released, the drive command is recessive and every fault latch is cleared.

Top module: `lin_tx_guard`

## Requirements
- R1: `drive_dom` is 1 only while `rst_n` is 1, `norm_mode` is 1, `txd_in` is 0 and no fault blocks transmission. With no fault present, it follows the inverse of `txd_in` with no cycle of delay.
- R2: Once `txd_in` has been sampled 0 on `TIMEOUT_CYC` consecutive rising edges in normal mode, `drive_dom` is 0 and stays 0 while `txd_in` stays 0.
- R3: A timeout ends at the first rising edge that samples `txd_in` at 1. Any sample of `txd_in` at 1 restarts the count of consecutive low samples from zero.
- R4: While `tsd_flag` is 1, `drive_dom` is 0 in that same cycle.
- R5: After `tsd_flag` returns to 0, `drive_dom` stays 0 until a rising edge samples `txd_in` at 1 with `tsd_flag` at 0.
- R6: While `batt_low` (battery below the low threshold) is 1, `drive_dom` is 0 in that same cycle.
- R7: After `batt_low` has been sampled at 1, transmission stays disabled until a rising edge samples `batt_high` (battery at or above the high threshold) at 1 with `batt_low` at 0.
- R8: In normal mode, `rxd_out` equals `bus_rx` (0 = dominant, 1 = recessive) in every cycle, including while a timeout, thermal or undervoltage block is active.
- R9: While `norm_mode` is 0, `drive_dom` is 0 and `rxd_out` is 1. A rising edge with `norm_mode` at 0 clears the timeout count and all three fault latches, so a return to normal mode with `txd_in` at 0 drives dominant at once.
- R10: While `rst_n` is 0, `drive_dom` is 0 and all fault state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| norm_mode | input | 1 | 1 while the transceiver is in normal mode |
| txd_in | input | 1 | Transmit data: 0 requests dominant, 1 requests recessive |
| tsd_flag | input | 1 | Thermal shutdown active |
| batt_low | input | 1 | Battery below the low monitor threshold |
| batt_high | input | 1 | Battery at or above the high monitor threshold |
| bus_rx | input | 1 | Received bus level: 0 dominant, 1 recessive |
| drive_dom | output | 1 | Command to drive the bus dominant |
| rxd_out | output | 1 | Receive data: 0 for dominant, 1 released |

## Verification
The checker tests the immediate fault gating on every cycle: thermal flag, low battery and mode. It also tests the receive mapping, the one-cycle persistence of the thermal lockout and the undervoltage block, and the release after a run of low transmit samples, which it measures with a counter of its own. Some behaviours depend on a sequence of events, and only the bench scenarios show them. These are the exact edge at which the timeout fires, the counter restart after a single high sample, recovery that waits for a high transmit level or a high battery flag, and the clearing of all latches on a mode exit.

// File: rtl/lin_tx_guard.sv
module lin_tx_guard #(
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic norm_mode,
  input  logic txd_in,
  input  logic tsd_flag,
  input  logic batt_low,
  input  logic batt_high,
  input  logic bus_rx,
  output logic drive_dom,
  output logic rxd_out
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] CNT_FIRE = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic to_lat, th_lat, uv_lat;
  logic tx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      to_lat  <= 1'b0;
      th_lat  <= 1'b0;
      uv_lat  <= 1'b0;
    end else if (!norm_mode) begin
      low_cnt <= '0;
      to_lat  <= 1'b0;
      th_lat  <= 1'b0;
      uv_lat  <= 1'b0;
    end else begin
      if (txd_in)                  low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;

      if (txd_in)                  to_lat <= 1'b0;
      else if (low_cnt >= CNT_FIRE) to_lat <= 1'b1;

      if (tsd_flag)                th_lat <= 1'b1;
      else if (txd_in)             th_lat <= 1'b0;

      if (batt_low)                uv_lat <= 1'b1;
      else if (batt_high)          uv_lat <= 1'b0;
    end
  end

  assign tx_ok     = ~to_lat & ~th_lat & ~tsd_flag & ~batt_low & ~uv_lat;
  assign drive_dom = rst_n & norm_mode & ~txd_in & tx_ok;
  assign rxd_out   = ~norm_mode | bus_rx;

endmodule

// File: rtl/lin_tx_guard_chk.sv
module lin_tx_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic norm_mode,
  input logic txd_in,
  input logic tsd_flag,
  input logic batt_low,
  input logic batt_high,
  input logic bus_rx,
  input logic drive_dom,
  input logic rxd_out
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run <= 0;
    else if (!norm_mode || txd_in)   run <= 0;
    else if (run < TIMEOUT_CYC)      run <= run + 1;
  end

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run >= TIMEOUT_CYC) |-> !drive_dom);                                  // R2
  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    drive_dom |-> (norm_mode && !txd_in));                                  // R1
  AST_TSD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |-> !drive_dom);                                               // R4
  AST_TSD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tsd_flag) && $past(norm_mode) && norm_mode) |-> !drive_dom);     // R5
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    batt_low |-> !drive_dom);                                               // R6
  AST_UV_HYST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(batt_low) && $past(norm_mode) && norm_mode) |-> !drive_dom);     // R7
  AST_RX_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    norm_mode |-> (rxd_out == bus_rx));                                     // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_mode |-> (!drive_dom && rxd_out));                                // R9
  AST_RESET_QUIET: assert property (@(negedge clk)
    !rst_n |-> !drive_dom);                                                 // R10
endmodule

bind lin_tx_guard lin_tx_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/test_lin_tx_guard.sv
`timescale 1ns/1ps
module test_lin_tx_guard;
  localparam int unsigned LIM = 8;

  logic clk = 1'b0;
  logic rst_n, norm_mode, txd_in, tsd_flag, batt_low, batt_high, bus_rx;
  logic drive_dom, rxd_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lin_tx_guard #(.TIMEOUT_CYC(LIM)) i_lin_tx_guard (.*);

  // {norm, txd, tsd, blow, bhigh, bus, exp_drive, exp_rxd}
  localparam logic [7:0] VEC [8] = '{
    8'b1_1_0_0_1_1_0_1, 8'b1_0_0_0_1_0_1_0, 8'b1_1_0_0_1_0_0_0, 8'b0_0_0_0_1_0_0_1,
    8'b0_1_0_0_1_1_0_1, 8'b1_0_0_0_1_1_1_1, 8'b1_1_0_0_0_1_0_1, 8'b1_0_0_0_0_0_1_0};

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; norm_mode = 1; txd_in = 0; tsd_flag = 0;
    batt_low = 0; batt_high = 1; bus_rx = 0;
    step(3);
    chk(drive_dom, 1'b0, "R10", "drive in reset");
    chk(rxd_out, 1'b0, "R8", "rx in reset");
    txd_in = 1; rst_n = 1;
    step(1);

    // R1 / R8 / R9 table
    for (int i = 0; i < 8; i++) begin
      {norm_mode, txd_in, tsd_flag, batt_low, batt_high, bus_rx} = VEC[i][7:2];
      #1;
      chk(drive_dom, VEC[i][1], "R1", $sformatf("vec %0d drive", i));
      chk(rxd_out,   VEC[i][0], "R8", $sformatf("vec %0d rx", i));
      step(1);
    end
    norm_mode = 1; txd_in = 1; batt_high = 1; bus_rx = 1;
    step(1);

    // R2 timeout
    txd_in = 0; bus_rx = 0;
    step(LIM - 1);
    chk(drive_dom, 1'b1, "R2", "before limit");
    step(1);
    chk(drive_dom, 1'b0, "R2", "at limit");
    step(4);
    chk(drive_dom, 1'b0, "R2", "held released");
    chk(rxd_out, 1'b0, "R8", "rx during timeout");
    txd_in = 1; step(1);
    txd_in = 0; #1;
    chk(drive_dom, 1'b1, "R3", "recover after high");
    txd_in = 1; step(1);

    // R3 restart on high blip
    txd_in = 0; step(LIM - 2);
    txd_in = 1; step(1);
    txd_in = 0; step(LIM - 1);
    chk(drive_dom, 1'b1, "R3", "count restarted");
    step(1);
    chk(drive_dom, 1'b0, "R3", "timeout after restart");
    txd_in = 1; step(1);

    // R4 / R5 thermal
    txd_in = 0; tsd_flag = 1; #1;
    chk(drive_dom, 1'b0, "R4", "tsd immediate");
    step(2);
    tsd_flag = 0; #1;
    chk(drive_dom, 1'b0, "R5", "locked after tsd clear");
    step(2);
    chk(drive_dom, 1'b0, "R5", "still locked, txd low");
    txd_in = 1; step(1);
    txd_in = 0; #1;
    chk(drive_dom, 1'b1, "R5", "unlocked after high");
    txd_in = 1; step(1);

    // R6 / R7 undervoltage
    txd_in = 0; batt_low = 1; batt_high = 0; bus_rx = 1; #1;
    chk(drive_dom, 1'b0, "R6", "low battery immediate");
    chk(rxd_out, 1'b1, "R8", "rx during undervoltage");
    step(1);
    batt_low = 0; #1;
    chk(drive_dom, 1'b0, "R7", "between thresholds");
    step(1);
    chk(drive_dom, 1'b0, "R7", "still between thresholds");
    batt_high = 1; #1;
    chk(drive_dom, 1'b0, "R7", "high seen, not yet sampled");
    step(1);
    chk(drive_dom, 1'b1, "R7", "re-enabled");
    txd_in = 1; step(1);

    // R9 mode exit clears timeout
    txd_in = 0; step(LIM);
    chk(drive_dom, 1'b0, "R9", "timed out before exit");
    norm_mode = 0; bus_rx = 0; #1;
    chk(drive_dom, 1'b0, "R9", "idle drive");
    chk(rxd_out, 1'b1, "R9", "idle rx released");
    step(1);
    norm_mode = 1; #1;
    chk(drive_dom, 1'b1, "R9", "timeout cleared on exit");
    // R9 mode exit clears thermal and undervoltage latches
    tsd_flag = 1; batt_low = 1; batt_high = 0; step(1);
    tsd_flag = 0; batt_low = 0; norm_mode = 0; step(1);
    norm_mode = 1; #1;
    chk(drive_dom, 1'b1, "R9", "thermal/uv cleared on exit");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule